// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial-peripheral master that sits on a simple byte-addressed register port. Software programs a bit-rate divisor, a command word (frame length, clock polarity, clock phase, bit order, which of two chip selects to use and whether that select stays held), and the active level of each select line. Writing the data register starts a frame. The block shifts the word out on MOSI and shifts a word in from MISO. It then reports through transmit-empty, receive-full and overrun flags and one interrupt line.

To receive only, software writes a dummy word in full-duplex mode and reads the returned word. In transmit-only mode the received bits are dropped and the receive flags never move. The register port has no stall: every write or read completes in the cycle it is presented, and read data is combinational on the address. There is no streaming interface, so no back-pressure rules apply; software paces traffic with the status flags.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the status register (offset 0x03) reads 0x20, the interrupt is low, SCK is 0 and both select outputs are 1 (inactive for the reset polarity 0 = active low).
- R2: SCK holds each level for N+1 clock cycles, where N is the 8-bit rate register at offset 0x0A, giving a serial period of 2(N+1) clocks.
- R3: Frame length comes from command bits 11:8: codes 7 to 15 give code+1 bits, code 0 gives 20, code 1 gives 24, code 2 gives 32, and codes 3 to 6 give 8.
- R4: Command bit 1 (CPOL) sets the SCK idle level. Command bit 0 (CPHA) chooses sampling on the first edge of each bit (0) or on the second edge (1), with the opposite edge used for driving.
- R5: Command bit 12 set sends and assembles the word least-significant bit first; clear sends it most-significant bit first.
- R6: Command bit 4 chooses select line 1 (set) or line 0 (clear). Select-polarity bits 1:0 (offset 0x01) make a line active high when set. The chosen line is active while control bit 6 (enable) is set and either a frame is running or command bit 7 (hold) is set.
- R7: A frame that completes while receive-full is set raises overrun (status bit 0) and leaves the receive register unchanged. Writing the status register with bit 0 clear clears overrun.
- R8: With control bit 1 (transmit-only) set, a finished frame changes neither receive-full nor overrun.
- R9: Status bit 5 (transmit-empty) clears on a data-register write (offset 0x04) and sets when that word enters the shifter, which happens only while enable is set. Status bit 7 (receive-full) sets at the end of a full-duplex frame and clears on a data-register read. Status bit 1 reads 1 while a frame is running.
- R10: The interrupt is high exactly when receive-full with control bit 7, transmit-empty with control bit 5, or overrun with control bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data read clears receive-full) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_sel | output | 2 | Slave selects, level set by the polarity register |

## Verification
A bench-side slave sweeps every clock mode, both bit orders, the three special length codes and three ordinary lengths, at two divisor values. Each word is a distinct arithmetic pattern, so a swapped order, a wrong edge or a miscounted length shows up as a changed bit. The slave also counts its sampled bits, which separates a truncated frame from a shifted one, and it times the first half period of each frame. Directed frames then test the flag, overrun, transmit-only, interrupt and select cases one at a time. Each of those cases has its own expected status byte.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int MAX_BITS = 32;
  localparam int BCNT_W   = $clog2(MAX_BITS + 1);
  localparam int SEL_N    = 2;
  localparam int ADDR_W   = 5;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_SELPOL = 5'h01;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'h03;
  localparam logic [ADDR_W-1:0] A_DATA   = 5'h04;
  localparam logic [ADDR_W-1:0] A_RATE   = 5'h0A;
  localparam logic [ADDR_W-1:0] A_CMD    = 5'h10;

  typedef struct packed {
    logic       lsbf;
    logic [3:0] len_code;
    logic       hold;
    logic       line;
    logic       cpol;
    logic       cpha;
  } cmd_t;

  function automatic logic [BCNT_W-1:0] frame_bits(input logic [3:0] code);
    case (code)
      4'h0:                   return BCNT_W'(20);
      4'h1:                   return BCNT_W'(24);
      4'h2:                   return BCNT_W'(32);
      4'h3, 4'h4, 4'h5, 4'h6: return BCNT_W'(8);
      default:                return BCNT_W'(code) + BCNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [BCNT_W-1:0]   nbits,
  input  logic                cpol,
  input  logic                cpha,
  input  logic                lsbf,
  input  logic [RATE_W-1:0]   rate,
  input  logic                miso,
  output logic                busy,
  output logic                sck,
  output logic                mosi,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_word
);
  localparam int IDX_W = $clog2(MAX_BITS);

  logic [RATE_W-1:0]   div;
  logic                half;
  logic [BCNT_W-1:0]   bcnt, lcnt, nb, out_ptr;
  logic [MAX_BITS-1:0] txw, rxsh, rx_next;
  logic                ph, po, lf, edge_now;

  function automatic logic [IDX_W-1:0] bit_pos(input logic [BCNT_W-1:0] k);
    logic [BCNT_W-1:0] p;
    p = lf ? k : (nb - k - BCNT_W'(1));
    return p[IDX_W-1:0];
  endfunction

  assign edge_now = busy && (div == rate);

  always_comb begin
    out_ptr = ph ? ((lcnt == '0) ? '0 : lcnt - BCNT_W'(1)) : bcnt;
  end

  always_comb begin
    rx_next = rxsh;
    if (edge_now && (half == ph)) rx_next[bit_pos(bcnt)] = miso;
  end

  assign mosi    = txw[bit_pos(out_ptr)];
  assign rx_word = rxsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sck <= 1'b0; done <= 1'b0; div <= '0; half <= 1'b0;
      bcnt <= '0; lcnt <= '0; nb <= BCNT_W'(8); txw <= '0; rxsh <= '0;
      ph <= 1'b0; po <= 1'b0; lf <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck  <= cpol;
        div  <= '0;
        half <= 1'b0;
        bcnt <= '0;
        lcnt <= '0;
        if (start) begin
          busy <= 1'b1; txw <= tx_word; nb <= nbits;
          ph <= cpha; po <= cpol; lf <= lsbf; rxsh <= '0;
        end
      end else if (edge_now) begin
        div  <= '0;
        half <= ~half;
        sck  <= po ^ ~half;
        rxsh <= rx_next;
        if (!half) begin
          lcnt <= lcnt + BCNT_W'(1);
        end else begin
          bcnt <= bcnt + BCNT_W'(1);
          if (bcnt == nb - BCNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end else begin
        div <= div + RATE_W'(1);
      end
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [MAX_BITS-1:0] wdata,
  output logic [MAX_BITS-1:0] rdata,
  input  logic                busy,
  input  logic                done,
  input  logic [MAX_BITS-1:0] rx_word,
  output logic                start,
  output logic [MAX_BITS-1:0] tx_word,
  output cmd_t                cmd,
  output logic [RATE_W-1:0]   rate,
  output logic                en,
  output logic                tx_only,
  output logic [SEL_N-1:0]    sel_pol,
  output logic                irq,
  output logic                tx_empty,
  output logic                rx_full,
  output logic                ovr,
  output logic                data_wr
);
  logic [7:0]          ctrl;
  logic [15:0]         cmd_r;
  logic [MAX_BITS-1:0] rxbuf;
  logic                data_rd, stat_wr;

  assign en      = ctrl[6];
  assign tx_only = ctrl[1];
  assign data_wr = wr_en && (addr == A_DATA);
  assign data_rd = rd_en && (addr == A_DATA);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign start   = en && !tx_empty && !busy;

  assign cmd.cpha     = cmd_r[0];
  assign cmd.cpol     = cmd_r[1];
  assign cmd.line     = cmd_r[4];
  assign cmd.hold     = cmd_r[7];
  assign cmd.len_code = cmd_r[11:8];
  assign cmd.lsbf     = cmd_r[12];

  assign irq = (rx_full && ctrl[7]) || (tx_empty && ctrl[5]) || (ovr && ctrl[4]);

  always_comb begin
    case (addr)
      A_CTRL:   rdata = MAX_BITS'(ctrl);
      A_SELPOL: rdata = MAX_BITS'(sel_pol);
      A_STAT:   rdata = MAX_BITS'({rx_full, 1'b0, tx_empty, 3'b000, busy, ovr});
      A_DATA:   rdata = rxbuf;
      A_RATE:   rdata = MAX_BITS'(rate);
      A_CMD:    rdata = MAX_BITS'(cmd_r);
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; sel_pol <= '0; rate <= '0; cmd_r <= '0; tx_word <= '0;
      tx_empty <= 1'b1; rxbuf <= '0; rx_full <= 1'b0; ovr <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTRL:   ctrl    <= wdata[7:0];
          A_SELPOL: sel_pol <= wdata[SEL_N-1:0];
          A_RATE:   rate    <= wdata[RATE_W-1:0];
          A_CMD:    cmd_r   <= wdata[15:0];
          default:  ;
        endcase
      end
      if (start) tx_empty <= 1'b1;
      if (data_wr) begin
        tx_word  <= wdata;
        tx_empty <= 1'b0;
      end
      if (data_rd) rx_full <= 1'b0;
      if (stat_wr && !wdata[0]) ovr <= 1'b0;
      if (done && !tx_only) begin
        if (rx_full && !data_rd) begin
          ovr <= 1'b1;
        end else begin
          rxbuf   <= rx_word;
          rx_full <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [MAX_BITS-1:0] reg_wdata,
  output logic [MAX_BITS-1:0] reg_rdata,
  output logic                irq,
  output logic                spi_sck,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic [SEL_N-1:0]    spi_sel
);
  cmd_t                cmd_f;
  logic                en, tx_only, eng_busy, eng_done, start;
  logic                tx_empty, rx_full, ovr_flag, data_wr, cpol, sel_on;
  logic [SEL_N-1:0]    sel_pol, sel_act;
  logic [RATE_W-1:0]   rate;
  logic [MAX_BITS-1:0] tx_word, rx_word;
  logic [BCNT_W-1:0]   nbits;

  assign nbits  = frame_bits(cmd_f.len_code);
  assign cpol   = cmd_f.cpol;
  assign sel_on = en && (eng_busy || cmd_f.hold);

  spim_regs #(.RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(eng_busy), .done(eng_done),
    .rx_word(rx_word), .start(start), .tx_word(tx_word), .cmd(cmd_f), .rate(rate),
    .en(en), .tx_only(tx_only), .sel_pol(sel_pol), .irq(irq), .tx_empty(tx_empty),
    .rx_full(rx_full), .ovr(ovr_flag), .data_wr(data_wr)
  );

  spim_engine #(.RATE_W(RATE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .nbits(nbits),
    .cpol(cmd_f.cpol), .cpha(cmd_f.cpha), .lsbf(cmd_f.lsbf), .rate(rate),
    .miso(spi_miso), .busy(eng_busy), .sck(spi_sck), .mosi(spi_mosi),
    .done(eng_done), .rx_word(rx_word)
  );

  for (genvar i = 0; i < SEL_N; i++) begin : g_sel
    assign sel_act[i] = sel_on && (cmd_f.line == i[0]);
    assign spi_sel[i] = sel_pol[i] ? sel_act[i] : ~sel_act[i];
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
  import spim_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             busy,
  input logic             cpol,
  input logic             rx_full,
  input logic             ovr,
  input logic             tx_only,
  input logic             tx_empty,
  input logic             data_wr,
  input logic [SEL_N-1:0] sel_act
);
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol)); // R4

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_act)); // R6

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_full)); // R7

  AST_TXONLY_NO_RXF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !$past(tx_only)); // R8

  AST_TXE_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(data_wr)); // R9

  AST_TXE_SET_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $rose(busy)); // R9
endmodule

bind spim_ctrl spim_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .busy(eng_busy), .cpol(cpol),
  .rx_full(rx_full), .ovr(ovr_flag), .tx_only(tx_only), .tx_empty(tx_empty),
  .data_wr(data_wr), .sel_act(sel_act)
);

// File: tb/tb_spim_ctrl.sv
module tb_spim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, spi_sck, spi_mosi, spi_miso;
  logic [1:0]  spi_sel;

  always #4 clk = ~clk;

  spim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_sel(spi_sel)
  );

  int checks = 0, errors = 0;

  // bench-side slave
  logic [31:0] s_pat = '0, s_got = '0;
  int          s_len = 8, s_nlead = 0, s_ntrail = 0, s_ns = 0;
  logic        s_lsb = 0, s_cpha = 0, s_cpol = 0, s_arm = 0;
  longint      t0 = 0, t1 = 0;

  function automatic int sidx(input int k);
    return (s_lsb ? k : (s_len - 1 - k)) & 31;
  endfunction

  assign spi_miso = s_pat[sidx(s_cpha ? ((s_nlead == 0) ? 0 : s_nlead - 1) : s_ntrail)];

  always @(posedge spi_sck or negedge spi_sck) begin
    if (s_arm) begin
      if (spi_sck != s_cpol) begin
        if (s_nlead == 0) t0 = $time;
        if (!s_cpha) begin s_got[sidx(s_ns)] = spi_mosi; s_ns++; end
        s_nlead++;
      end else begin
        if (s_ntrail == 0) t1 = $time;
        if (s_cpha) begin s_got[sidx(s_ns)] = spi_mosi; s_ns++; end
        s_ntrail++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      rd(5'h03, st);
      if (!st[1]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] tx, input logic [31:0] pat);
    s_pat = pat; s_got = '0; s_nlead = 0; s_ntrail = 0; s_ns = 0; s_arm = 1'b1;
    wr(5'h04, tx);
    wait_idle();
    s_arm = 1'b0;
  endtask

  function automatic int code_len(input int c);
    if (c >= 7) return c + 1;
    if (c == 0) return 20;
    if (c == 1) return 24;
    if (c == 2) return 32;
    return 8;
  endfunction

  function automatic logic [31:0] lmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got %h exp %h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] d, tx, pat;
    int codes[6] = '{7, 11, 15, 0, 1, 2};
    int rates[2] = '{0, 2};
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h03, d);
    chk(d == 32'h20, "R1 status", d, 32'h20);
    chk({irq, spi_sck, spi_sel} == 4'b0011, "R1 pins", {irq, spi_sck, spi_sel}, 4'b0011);

    // sweep: rate x mode x order x length
    wr(5'h00, 32'h48);
    n = 0;
    foreach (rates[ri]) begin
      wr(5'h0A, rates[ri]);
      for (int m = 0; m < 4; m++) begin
        for (int lsb = 0; lsb < 2; lsb++) begin
          foreach (codes[ci]) begin
            n++;
            s_len = code_len(codes[ci]); s_lsb = lsb[0]; s_cpha = m[0]; s_cpol = m[1];
            wr(5'h10, (lsb << 12) | (codes[ci] << 8) | m);
            repeat (3) @(negedge clk);
            tx  = 32'hA5C3_0F1E ^ (n * 32'h9E37_79B9);
            pat = 32'h3C69_D2E1 + (n * 32'h0101_3377);
            frame(tx, pat);
            rd(5'h04, d);
            chk(d == (pat & lmask(s_len)), lsb ? "R5 master rx" : "R4 master rx", d, pat & lmask(s_len));
            chk(s_got == (tx & lmask(s_len)), lsb ? "R5 slave rx" : "R4 slave rx", s_got, tx & lmask(s_len));
            chk(s_ns == s_len, "R3 frame length", s_ns, s_len);
            chk((t1 - t0) == (rates[ri] + 1) * 8, "R2 half period", 32'(t1 - t0), (rates[ri] + 1) * 8);
          end
        end
      end
    end

    // R4 idle level follows CPOL
    wr(5'h0A, 1);
    wr(5'h10, 32'h0702);
    repeat (3) @(negedge clk);
    chk(spi_sck == 1'b1, "R4 idle high", spi_sck, 1);
    wr(5'h10, 32'h0700);
    repeat (3) @(negedge clk);
    chk(spi_sck == 1'b0, "R4 idle low", spi_sck, 0);
    s_len = 8; s_lsb = 0; s_cpha = 0; s_cpol = 0;

    // R9 flags
    wr(5'h00, 32'h08);
    wr(5'h04, 32'h5A);
    repeat (4) @(negedge clk);
    rd(5'h03, d);
    chk(d == 32'h00, "R9 held without enable", d, 32'h00);
    wr(5'h00, 32'h48);
    wait_idle();
    rd(5'h03, d);
    chk(d == 32'hA0, "R9 after frame", d, 32'hA0);
    rd(5'h04, d);
    rd(5'h03, d);
    chk(d == 32'h20, "R9 read clears rxf", d, 32'h20);

    // R7 overrun
    frame(32'h11, 32'hC4);
    frame(32'h22, 32'h3B);
    rd(5'h03, d);
    chk(d == 32'hA1, "R7 overrun set", d, 32'hA1);
    // R10 error interrupt
    wr(5'h00, 32'h58);
    @(negedge clk);
    chk(irq == 1'b1, "R10 error irq", irq, 1);
    rd(5'h04, d);
    chk(d == 32'hC4, "R7 first word kept", d, 32'hC4);
    wr(5'h03, 32'h0);
    rd(5'h03, d);
    chk(d == 32'h20, "R7 overrun cleared", d, 32'h20);
    chk(irq == 1'b0, "R10 error irq off", irq, 0);

    // R10 transmit-empty and receive-full sources
    wr(5'h00, 32'h68);
    @(negedge clk);
    chk(irq == 1'b1, "R10 txe irq", irq, 1);
    wr(5'h00, 32'hC8);
    @(negedge clk);
    chk(irq == 1'b0, "R10 no rxf yet", irq, 0);
    frame(32'h33, 32'h99);
    chk(irq == 1'b1, "R10 rxf irq", irq, 1);
    rd(5'h04, d);
    @(negedge clk);
    chk(irq == 1'b0, "R10 rxf irq off", irq, 0);

    // R8 transmit-only
    wr(5'h00, 32'h4A);
    frame(32'h44, 32'h77);
    rd(5'h03, d);
    chk(d == 32'h20, "R8 no rx flag", d, 32'h20);
    frame(32'h45, 32'h78);
    rd(5'h03, d);
    chk(d == 32'h20, "R8 no overrun", d, 32'h20);
    chk(s_got == 32'h45, "R8 still transmits", s_got, 32'h45);

    // R6 selects
    wr(5'h00, 32'h48);
    wr(5'h01, 32'h1);
    wr(5'h10, 32'h0710);
    repeat (2) @(negedge clk);
    chk(spi_sel == 2'b10, "R6 idle levels", spi_sel, 2'b10);
    wr(5'h04, 32'h0F);
    repeat (4) @(negedge clk);
    chk(spi_sel == 2'b00, "R6 line1 active", spi_sel, 2'b00);
    wait_idle();
    chk(spi_sel == 2'b10, "R6 released", spi_sel, 2'b10);
    rd(5'h04, d);
    wr(5'h10, 32'h0700);
    wr(5'h04, 32'h0F);
    repeat (4) @(negedge clk);
    chk(spi_sel == 2'b11, "R6 line0 active high", spi_sel, 2'b11);
    wait_idle();
    rd(5'h04, d);
    wr(5'h10, 32'h0790);
    repeat (2) @(negedge clk);
    chk(spi_sel == 2'b00, "R6 hold while enabled", spi_sel, 2'b00);
    wr(5'h00, 32'h08);
    @(negedge clk);
    chk(spi_sel == 2'b10, "R6 hold ends with enable", spi_sel, 2'b10);

    finish_run();
  end
endmodule